// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, one cycle at a time, whether the core enters an exception, and works out what that entry writes. It folds a vector of external interrupt lines through a mask into the Cause IP2 pending bit. It gates interrupts with the Status enable, exception-level and error-level bits. When the pipeline raises a general exception, an address error or a TLB read or write miss, it computes the new values of Cause, Status, EPC, BadVAddr, Context, XContext and EntryHi. It also computes the address the fetch unit must jump to.

The architectural registers live outside the block. Their current values come in on `*_in` ports. The updated values leave on `*_out` ports, one clock after the request. Each register that is to be written has its own write-enable strobe, and Cause and Status are written on every entry. The pipeline supplies the faulting PC, a branch-delay-slot flag, the faulting virtual address and a flag saying whether a matching TLB entry exists. The TLB lookup itself is done elsewhere.

Top module: `exc_entry`

## Requirements
- R1: `cause_ip2` shows, one clock later, whether any bit of `irq_src AND irq_mask` was set, and `cause_out` bit 10 carries the same value on an entry.
- R2: An interrupt is taken only when `status_in` bit 0 (IE) is 1, bit 1 (EXL) is 0, bit 2 (ERL) is 0, and `status_in AND cause_in AND 0xFF00` is non-zero. A taken interrupt writes exception code 0 and coprocessor field 0.
- R3: When an entry writes EPC, `cause_out` bit 31 (BD) equals `in_delay`. `epc_out` is `pc - 4` if `in_delay` is set and `pc` otherwise, computed modulo 2^32 and sign-extended to 64 bits.
- R4: Every entry sets `status_out` bit 1 and keeps the other Status bits. General exceptions, interrupts and address errors redirect to 0x80000180.
- R5: An address error (`exc_kind` 1 = read, 2 = write) writes exception code 4 or 5 into Cause bits 6:2 and clears Cause bits 29:28. It writes the faulting address to BadVAddr. It puts address bits 31:13 into Context bits 22:4. It puts address bits 39:13 into XContext bits 30:4 and address bits 62:61 into XContext bits 32:31. All other Context and XContext bits keep their input values.
- R6: A TLB miss (`exc_kind` 3 = read, 4 = write) writes exception code 2 or 3, clears Cause bits 29:28, and writes BadVAddr and Context as in R5. It writes EntryHi as the address AND 0xFFFFE000 and leaves XContext alone.
- R7: On a TLB miss with EXL clear, the redirect is 0x80000000 when `tlb_hit` is 0 and 0x80000180 when `tlb_hit` is 1.
- R8: On a TLB miss with EXL already set, EPC is not written, Cause BD keeps its input value, and the redirect is 0x80000180.
- R9: At most one entry is accepted per clock, and an explicit request (`exc_req`) wins over a pending interrupt. `exc_kind` 0 and the unused values 5 to 7 are general exceptions that take `gen_code` and `gen_cop`. `redirect_vld` pulses for exactly one clock, one clock after acceptance.
- R10: During and right after reset, `redirect_vld`, `cause_ip2` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC | External interrupt lines |
| irq_mask | input | NSRC | Per-line interrupt enable mask |
| exc_req | input | 1 | Explicit exception request |
| exc_kind | input | 3 | 0 general, 1 read addr error, 2 write addr error, 3 TLB read miss, 4 TLB write miss |
| gen_code | input | 5 | Exception code for a general request |
| gen_cop | input | 2 | Coprocessor unit for a general request |
| pc | input | 32 | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| bad_addr | input | 64 | Faulting virtual address |
| tlb_hit | input | 1 | A matching TLB entry exists |
| status_in | input | 32 | Current Status |
| cause_in | input | 32 | Current Cause |
| context_in | input | 64 | Current Context |
| xcontext_in | input | 64 | Current XContext |
| cause_ip2 | output | 1 | Registered masked interrupt pending |
| redirect_vld | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Redirect vector |
| cause_out | output | 32 | New Cause, written with every redirect |
| status_out | output | 32 | New Status, written with every redirect |
| we_epc | output | 1 | Write EPC |
| epc_out | output | 64 | New EPC |
| we_badvaddr | output | 1 | Write BadVAddr |
| badvaddr_out | output | 64 | New BadVAddr |
| we_context | output | 1 | Write Context |
| context_out | output | 64 | New Context |
| we_xcontext | output | 1 | Write XContext |
| xcontext_out | output | 64 | New XContext |
| we_entryhi | output | 1 | Write EntryHi |
| entryhi_out | output | 64 | New EntryHi |

## Verification
The bench targets a TLB miss taken while EXL is already set. A design that ignored that state would overwrite EPC and use the refill vector, so the nested handler would lose its return address. It drives a delay-slot fault at a PC below 4. That case exposes an EPC computed in 64 bits or left zero-extended, because the result must wrap and then sign-extend to all ones. It probes each interrupt gate alone: IE clear, EXL set, ERL set, and a mask that misses the pending bits. A gate that was left out shows up as a spurious redirect. It also raises a request and a qualified interrupt in the same cycle. A design with the wrong priority would report code 0 instead of the requested code.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int NSRC = 8,
  parameter logic [31:0] VEC_GENERAL = 32'h8000_0180,
  parameter logic [31:0] VEC_REFILL  = 32'h8000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_src,
  input  logic [NSRC-1:0]  irq_mask,
  input  logic             exc_req,
  input  logic [2:0]       exc_kind,
  input  logic [4:0]       gen_code,
  input  logic [1:0]       gen_cop,
  input  logic [31:0]      pc,
  input  logic             in_delay,
  input  logic [63:0]      bad_addr,
  input  logic             tlb_hit,
  input  logic [31:0]      status_in,
  input  logic [31:0]      cause_in,
  input  logic [63:0]      context_in,
  input  logic [63:0]      xcontext_in,
  output logic             cause_ip2,
  output logic             redirect_vld,
  output logic [31:0]      redirect_pc,
  output logic [31:0]      cause_out,
  output logic [31:0]      status_out,
  output logic             we_epc,
  output logic [63:0]      epc_out,
  output logic             we_badvaddr,
  output logic [63:0]      badvaddr_out,
  output logic             we_context,
  output logic [63:0]      context_out,
  output logic             we_xcontext,
  output logic [63:0]      xcontext_out,
  output logic             we_entryhi,
  output logic [63:0]      entryhi_out
);

  localparam int ST_IE = 0, ST_EXL = 1, ST_ERL = 2;
  localparam int CA_BD = 31, CA_IP2 = 10;

  logic ip2_now, irq_ok, accept;
  logic is_ade, is_tlb, ade_wr, tlb_wr, exl_now, keep_epc;
  logic [31:0] epc32, vec_n, cause_n;
  logic [4:0]  code_n;
  logic [1:0]  cop_n;

  assign ip2_now  = |(irq_src & irq_mask);
  assign exl_now  = status_in[ST_EXL];
  assign irq_ok   = status_in[ST_IE] & ~exl_now & ~status_in[ST_ERL]
                  & |(status_in[15:8] & cause_in[15:8]);
  assign accept   = exc_req | irq_ok;

  assign is_ade   = exc_req & (exc_kind == 3'd1 || exc_kind == 3'd2);
  assign is_tlb   = exc_req & (exc_kind == 3'd3 || exc_kind == 3'd4);
  assign ade_wr   = exc_kind == 3'd2;
  assign tlb_wr   = exc_kind == 3'd4;
  assign keep_epc = is_tlb & exl_now;

  assign epc32 = in_delay ? pc - 32'd4 : pc;

  always_comb begin
    if (is_ade)      begin code_n = ade_wr ? 5'd5 : 5'd4; cop_n = 2'd0; end
    else if (is_tlb) begin code_n = tlb_wr ? 5'd3 : 5'd2; cop_n = 2'd0; end
    else if (exc_req) begin code_n = gen_code; cop_n = gen_cop; end
    else             begin code_n = 5'd0; cop_n = 2'd0; end
  end

  always_comb begin
    cause_n = cause_in;
    cause_n[6:2]   = code_n;
    cause_n[29:28] = cop_n;
    cause_n[CA_IP2] = ip2_now;
    if (!keep_epc) cause_n[CA_BD] = in_delay;
  end

  assign vec_n = (is_tlb && !exl_now && !tlb_hit) ? VEC_REFILL : VEC_GENERAL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_ip2    <= 1'b0;
      redirect_vld <= 1'b0;
      we_epc       <= 1'b0;
      we_badvaddr  <= 1'b0;
      we_context   <= 1'b0;
      we_xcontext  <= 1'b0;
      we_entryhi   <= 1'b0;
      redirect_pc  <= '0;
      cause_out    <= '0;
      status_out   <= '0;
      epc_out      <= '0;
      badvaddr_out <= '0;
      context_out  <= '0;
      xcontext_out <= '0;
      entryhi_out  <= '0;
    end else begin
      cause_ip2    <= ip2_now;
      redirect_vld <= accept;
      we_epc       <= accept & ~keep_epc;
      we_badvaddr  <= is_ade | is_tlb;
      we_context   <= is_ade | is_tlb;
      we_xcontext  <= is_ade;
      we_entryhi   <= is_tlb;
      if (accept) begin
        redirect_pc  <= vec_n;
        cause_out    <= cause_n;
        status_out   <= status_in | (32'd1 << ST_EXL);
        epc_out      <= {{32{epc32[31]}}, epc32};
        badvaddr_out <= bad_addr;
        context_out  <= {context_in[63:23], bad_addr[31:13], context_in[3:0]};
        xcontext_out <= {xcontext_in[63:33], bad_addr[62:61], bad_addr[39:13], xcontext_in[3:0]};
        entryhi_out  <= {32'd0, bad_addr[31:13], 13'd0};
      end
    end
  end

endmodule

module exc_entry_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src,
  input logic [NSRC-1:0] irq_mask,
  input logic            exc_req,
  input logic [2:0]      exc_kind,
  input logic [31:0]     status_in,
  input logic [31:0]     cause_in,
  input logic            cause_ip2,
  input logic            redirect_vld,
  input logic [31:0]     redirect_pc,
  input logic [31:0]     status_out,
  input logic [63:0]     epc_out,
  input logic            we_epc,
  input logic            we_entryhi,
  input logic            we_xcontext
);

  p_ip2_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cause_ip2 == $past(|(irq_src & irq_mask)));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && (!status_in[0] || status_in[1] || status_in[2])) |=> !redirect_vld);

  p_epc_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_epc |-> epc_out[63:32] == {32{epc_out[31]}});

  p_exl_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> status_out[1]);

  p_ade_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_xcontext |-> redirect_pc == 32'h8000_0180);

  p_nested_tlb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_vld && we_entryhi && !we_epc) |-> redirect_pc == 32'h8000_0180);

  p_req_accepted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> redirect_vld);

  p_we_with_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_epc || we_entryhi || we_xcontext) |-> redirect_vld);

endmodule

bind exc_entry exc_entry_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/exc_entry_tb.sv
`timescale 1ns/1ps
module exc_entry_tb;
  localparam int NSRC = 8;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [NSRC-1:0] irq_src = 0, irq_mask = 0;
  logic exc_req = 0, in_delay = 0, tlb_hit = 0;
  logic [2:0] exc_kind = 0;
  logic [4:0] gen_code = 0;
  logic [1:0] gen_cop = 0;
  logic [31:0] pc = 0, status_in = 0, cause_in = 0;
  logic [63:0] bad_addr = 0, context_in = 0, xcontext_in = 0;

  logic cause_ip2, redirect_vld, we_epc, we_badvaddr, we_context, we_xcontext, we_entryhi;
  logic [31:0] redirect_pc, cause_out, status_out;
  logic [63:0] epc_out, badvaddr_out, context_out, xcontext_out, entryhi_out;

  exc_entry #(.NSRC(NSRC)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic e_ip2, e_vld, e_wepc, e_wbad, e_wctx, e_wxc, e_weh;
  logic [31:0] e_pc, e_cause, e_status;
  logic [63:0] e_epc, e_bad, e_ctx, e_xc, e_eh;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model();
    bit take, tlb, ade, nested;
    int code, cop;
    take = status_in[0] && !status_in[1] && !status_in[2] &&
           ((status_in & cause_in & 32'hFF00) != 0);
    e_ip2 = (irq_src & irq_mask) != 0;
    e_vld = exc_req || take;
    ade = exc_req && (exc_kind == 1 || exc_kind == 2);
    tlb = exc_req && (exc_kind == 3 || exc_kind == 4);
    nested = tlb && status_in[1];
    code = 0; cop = 0;
    if (exc_req) begin
      case (exc_kind)
        1: code = 4;
        2: code = 5;
        3: code = 2;
        4: code = 3;
        default: begin code = gen_code; cop = gen_cop; end
      endcase
    end
    e_cause = (cause_in & ~32'h3000_047C) | (code << 2) | (cop << 28) | (e_ip2 ? 32'h400 : 0);
    if (!nested) e_cause = in_delay ? (e_cause | 32'h8000_0000) : (e_cause & 32'h7FFF_FFFF);
    e_status = status_in | 2;
    e_epc = int'(pc - (in_delay ? 4 : 0));
    e_pc = (tlb && !status_in[1] && !tlb_hit) ? 32'h8000_0000 : 32'h8000_0180;
    e_wepc = e_vld && !nested;
    e_wbad = ade || tlb; e_wctx = ade || tlb; e_wxc = ade; e_weh = tlb;
    e_bad = bad_addr;
    e_ctx = (context_in & ~64'h7F_FFF0) | (((bad_addr >> 13) & 64'h7FFFF) << 4);
    e_xc = (xcontext_in & ~64'h1_FFFF_FFF0) | (((bad_addr >> 13) & 64'h7FF_FFFF) << 4)
         | (((bad_addr >> 61) & 3) << 31);
    e_eh = bad_addr & 64'hFFFF_E000;
  endfunction

  task automatic step(string req);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(req, "ip2", cause_ip2, e_ip2);
    chk(req, "vld", redirect_vld, e_vld);
    chk(req, "we", {we_epc, we_badvaddr, we_context, we_xcontext, we_entryhi},
        {e_wepc, e_wbad, e_wctx, e_wxc, e_weh});
    if (e_vld) begin
      chk(req, "vector", redirect_pc, e_pc);
      chk(req, "cause", cause_out, e_cause);
      chk(req, "status", status_out, e_status);
    end
    if (e_wepc) chk(req, "epc", epc_out, e_epc);
    if (e_wbad) chk(req, "badvaddr", badvaddr_out, e_bad);
    if (e_wctx) chk(req, "context", context_out, e_ctx);
    if (e_wxc)  chk(req, "xcontext", xcontext_out, e_xc);
    if (e_weh)  chk(req, "entryhi", entryhi_out, e_eh);
    exc_req = 0;
  endtask

  task automatic fault(logic [2:0] k, logic [31:0] p, logic d, logic [63:0] a, logic h);
    exc_req = 1; exc_kind = k; pc = p; in_delay = d; bad_addr = a; tlb_hit = h;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "vld in reset", redirect_vld, 0);
    chk("R10", "we in reset", {we_epc, we_badvaddr, we_context, we_xcontext, we_entryhi}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "vld after reset", redirect_vld, 0);
    chk("R10", "ip2 after reset", cause_ip2, 0);

    context_in  = 64'hDEAD_BEEF_0123_4567;
    xcontext_in = 64'hCAFE_F00D_8765_4321;
    cause_in    = 32'h0000_0300;

    // R1: interrupt source folding
    irq_src = 8'h10; irq_mask = 8'h01; step("R1");
    irq_mask = 8'h11; step("R1");
    irq_src = 8'h00; step("R1");
    irq_src = 8'hFF; irq_mask = 8'h80; step("R1");
    irq_src = 0; irq_mask = 0;

    // R2: each gate alone, then a taken interrupt
    cause_in = 32'h0000_0400;
    status_in = 32'h0000_0400; step("R2");
    status_in = 32'h0000_0403; step("R2");
    status_in = 32'h0000_0405; step("R2");
    status_in = 32'h0000_0801; step("R2");
    status_in = 32'h0000_0401; pc = 32'h8000_1000; in_delay = 0; step("R2");
    pc = 32'h8000_2000; in_delay = 1; step("R3");
    status_in = 0; cause_in = 0;

    // R9: general requests, priority over an interrupt
    gen_code = 5'd15; gen_cop = 2'd1; fault(3'd0, 32'h8000_0040, 0, 0, 0); step("R9");
    status_in = 32'h0000_0401; cause_in = 32'h0000_0400;
    gen_code = 5'd8; gen_cop = 2'd3; fault(3'd6, 32'h8000_0080, 1, 0, 0); step("R9");
    status_in = 0; cause_in = 0;
    step("R9");

    // R3: EPC wrap and sign extension
    gen_code = 5'd9; gen_cop = 0; fault(3'd0, 32'h0000_0002, 1, 0, 0); step("R3");
    fault(3'd0, 32'h7FFF_FFFC, 0, 0, 0); step("R3");

    // R4, R5: address errors
    fault(3'd1, 32'h8000_0300, 0, 64'hE123_4567_89AB_CDEF, 0); step("R5");
    fault(3'd2, 32'h8000_0304, 1, 64'h4000_00FF_FFFF_E001, 0); step("R5");
    status_in = 32'h0000_0002;
    fault(3'd1, 32'h8000_0308, 0, 64'h0000_0000_0000_1FFF, 0); step("R4");
    status_in = 0;

    // R6, R7: TLB misses with EXL clear
    fault(3'd3, 32'h8000_0400, 0, 64'hFFFF_FFFF_8765_4321, 0); step("R7");
    fault(3'd4, 32'h8000_0404, 1, 64'h0000_0001_2345_F000, 1); step("R6");
    fault(3'd3, 32'h8000_0408, 0, 64'h0000_0000_0040_2000, 1); step("R7");

    // R8: TLB miss with EXL set keeps EPC and BD
    status_in = 32'h0000_0002; cause_in = 32'h8000_0000;
    fault(3'd3, 32'h8000_0500, 0, 64'h0000_0000_1234_5678, 0); step("R8");
    cause_in = 32'h0000_0000;
    fault(3'd4, 32'h8000_0504, 1, 64'h0000_0000_ABCD_0000, 0); step("R8");
    status_in = 0;

    // R9: back-to-back requests each pulse
    fault(3'd0, 32'h8000_0600, 0, 0, 0); step("R9");
    fault(3'd4, 32'h8000_0604, 0, 64'h1000, 1); step("R9");
    step("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule